// File: doc/BRIEF.md
# Conversion interrupt and status logic

This block gathers the interrupt sources of a sequenced data-acquisition controller and presents them through a small byte-wide register port. Two sources come from live controller state. One fires when the executing sequencer instruction address equals a programmed trigger address. The other fires when the number of results held in the conversion FIFO equals a programmed count. Five further sources arrive as single-cycle event pulses from the rest of the controller.

Every source sets a sticky bit in a status register, whether or not that source is enabled. A mask register gates the status bits onto one interrupt line. Software reads the status register to learn which sources fired, and that read clears it. A separate read-only register shows the live FIFO count and sequencer address side by side. The FIFO and the sequencer themselves lie outside this block.

Top module: `seq_irq_status`

## Requirements
- R1: Status bit 1 is set on the clock edge after the sequencer address input becomes equal to the programmed trigger address.
- R2: Status bit 2 is set on the clock edge after the FIFO count input becomes equal to the programmed threshold count.
- R3: Register address 0 is the enable mask, readable and writable. Its bit 6 always reads 0, and writes to bit 6 are ignored.
- R4: A source's status bit is set whether or not it is enabled. `irq` is high exactly when some status bit and its enable bit are both 1.
- R5: Register address 2 returns the status register, whose bit 6 always reads 0. A read there (`rd_en` high) clears all status bits at the next edge.
- R6: Register address 3 is read-only and returns the FIFO count in bits [7:3] and the sequencer address in bits [2:0].
- R7: An event arriving in the same cycle as a status read is still set after that read. The read itself returns the value before the clear.
- R8: Reset clears the enable mask, the status bits, the threshold count and the trigger address.
- R9: A match that stays true does not set its status bit again after a status read. Only a false-to-true change sets it.
- R10: Register address 1 is writable and readable. It holds the threshold count in bits [7:3] and the trigger address in bits [2:0].
- R11: Event input bits 0, 1, 2, 3 and 4 set status bits 0, 3, 4, 5 and 7 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: clears status) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| fifo_cnt | input | CW (5) | Results currently in the conversion FIFO |
| seq_addr | input | AW (3) | Address of the executing sequencer instruction |
| evt | input | 5 | Event pulses for the other interrupt sources |
| rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take two things for granted. First, event pulses and register strobes are stable for a whole cycle. Second, `wr_en` and `rd_en` are never high together for the status address; the no-re-set property relies on status reads being the only thing that clears a bit.

The stimulus drives every input on the falling edge. It only issues status reads as single-cycle strobes. It holds the sequencer address and FIFO count at a matching value over several cycles, so that the edge-only behaviour is exercised against a held condition.

// File: rtl/seq_irq_status.sv
module seq_irq_status #(
  parameter int AW = 3,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [AW-1:0] seq_addr,
  input  logic [4:0]    evt,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam logic [7:0] EN_MASK = 8'hBF;

  logic [7:0]    en_q, st_q;
  logic [CW-1:0] thr_q;
  logic [AW-1:0] ta_q;
  logic          am_q, cm_q;

  wire am      = (seq_addr == ta_q);
  wire cm      = (fifo_cnt == thr_q);
  wire st_rd   = rd_en && (addr == 2'd2);
  wire [7:0] set_v = {evt[4], 1'b0, evt[3], evt[2], evt[1], cm & ~cm_q, am & ~am_q, evt[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      st_q  <= '0;
      thr_q <= '0;
      ta_q  <= '0;
      am_q  <= 1'b0;
      cm_q  <= 1'b0;
    end else begin
      am_q <= am;
      cm_q <= cm;
      st_q <= (st_rd ? 8'h00 : st_q) | set_v;
      if (wr_en) begin
        case (addr)
          2'd0:    en_q <= wdata & EN_MASK;
          2'd1:    {thr_q, ta_q} <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = en_q;
      2'd1:    rdata = {thr_q, ta_q};
      2'd2:    rdata = st_q;
      default: rdata = {fifo_cnt, seq_addr};
    endcase
  end

  assign irq = |(st_q & en_q);
endmodule

// File: rtl/seq_irq_status_chk.sv
module seq_irq_status_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [1:0]    addr,
  input logic [4:0]    evt,
  input logic          irq,
  input logic [7:0]    st_q,
  input logic [7:0]    en_q,
  input logic [7:0]    set_v,
  input logic          am,
  input logic          am_q
);
  wire st_rd = rd_en && (addr == 2'd2);

  // R5
  st6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !st_q[6]);
  // R3
  en6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q[6]);
  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n) (en_q == 8'h00) |-> !irq);
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_q[0] && !st_rd) |=> st_q[0]);
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_rd && set_v == 8'h00) |=> (st_q == 8'h00));
  // R7
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_rd && evt[0]) |=> st_q[0]);
  // R9
  no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_rd && am && am_q) |=> !st_q[1]);
  // R1
  addr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) (am && !am_q) |=> st_q[1]);
endmodule

bind seq_irq_status seq_irq_status_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .evt(evt), .irq(irq),
  .st_q(st_q), .en_q(en_q), .set_v(set_v), .am(am), .am_q(am_q)
);

// File: tb/seq_irq_status_tb.sv
module seq_irq_status_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [4:0] fifo_cnt = 5'd1, evt = 0;
  logic [2:0] seq_addr = 3'd1;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seq_irq_status u_dut (.*);

  int m_en, m_st, m_thr, m_ta;
  bit m_pa, m_pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_st = 0; m_thr = 0; m_ta = 0; m_pa = 0; m_pc = 0;
    end else begin
      bit ma, mc;
      int s;
      ma = (int'(seq_addr) == m_ta);
      mc = (int'(fifo_cnt) == m_thr);
      s = 0;
      if (evt[0]) s |= 1;
      if (evt[1]) s |= 8;
      if (evt[2]) s |= 16;
      if (evt[3]) s |= 32;
      if (evt[4]) s |= 128;
      if (ma && !m_pa) s |= 2;
      if (mc && !m_pc) s |= 4;
      if (rd_en && addr == 2) m_st = 0;
      m_st |= s;
      if (wr_en && addr == 0) m_en = int'(wdata) & 'hBF;
      if (wr_en && addr == 1) begin m_thr = int'(wdata) >> 3; m_ta = int'(wdata) & 7; end
      m_pa = ma; m_pc = mc;
    end
  end

  function automatic int exp_rd();
    case (addr)
      2'd0: return m_en;
      2'd1: return (m_thr << 3) | m_ta;
      2'd2: return m_st;
      default: return (int'(fifo_cnt) << 3) | int'(seq_addr);
    endcase
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d,
                      input logic [4:0] e, input logic [4:0] c, input logic [2:0] s);
    @(negedge clk);
    if (rst_n) begin
      chk(int'(rdata), exp_rd(), "R5 model rdata");
      chk(int'(irq), int'((m_st & m_en) != 0), "R4 model irq");
    end
    wr_en = w; rd_en = r; addr = a; wdata = d; evt = e; fifo_cnt = c; seq_addr = s;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 1, 1); chk(int'(rdata), 0, "R8 enable");
    chk(int'(irq), 0, "R8 irq");
    step(0, 0, 1, 0, 0, 1, 1); chk(int'(rdata), 0, "R8 config");
    step(0, 0, 2, 0, 0, 1, 1); chk(int'(rdata), 0, "R8 status");
    step(1, 0, 0, 8'hFF, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1); chk(int'(rdata), 'hBF, "R3 bit6");
    step(1, 0, 1, 8'h25, 0, 1, 1);
    step(0, 0, 1, 0, 0, 1, 1); chk(int'(rdata), 'h25, "R10 fields");
    step(0, 0, 3, 0, 0, 9, 6);  chk(int'(rdata), 'h4E, "R6 live");
    step(0, 0, 3, 0, 0, 1, 5);
    step(0, 1, 2, 0, 0, 1, 5);  chk(int'(rdata), 'h02, "R1 addr match");
    chk(int'(irq), 1, "R4 irq on");
    step(0, 0, 0, 0, 0, 1, 5);  chk(int'(irq), 0, "R5 cleared");
    step(0, 1, 2, 0, 0, 1, 5);  chk(int'(rdata), 'h00, "R9 held match");
    step(0, 0, 3, 0, 0, 4, 5);
    step(0, 1, 2, 0, 0, 4, 5);  chk(int'(rdata), 'h04, "R2 count match");
    step(0, 0, 3, 0, 5'h1F, 4, 5);
    step(0, 1, 2, 0, 0, 4, 5);  chk(int'(rdata), 'hB9, "R11 mapping");
    step(0, 1, 2, 0, 5'h01, 4, 5); chk(int'(rdata), 'h00, "R7 pre-clear");
    step(0, 1, 2, 0, 0, 4, 5);  chk(int'(rdata), 'h01, "R7 kept");
    step(1, 0, 0, 8'h00, 0, 4, 5);
    step(0, 0, 3, 0, 5'h02, 4, 5);
    step(0, 0, 2, 0, 0, 4, 5);  chk(int'(irq), 0, "R4 masked irq");
    chk(int'(rdata), 'h08, "R4 status unmasked");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a = 2'($urandom);
      step(($urandom % 5) == 0, ($urandom % 4) == 0, a, 8'($urandom),
           5'($urandom) & 5'($urandom), 5'($urandom % 6), 3'($urandom % 3));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule